// File: doc/BRIEF.md
# Monochrome Scan Renderer Without Frame Memory

This block produces the raster timing for a 640x480 display refreshed at about 59.94 Hz, clocked at a pixel rate near 25.175 MHz. The line period is 31.77 µs. A single green video bit is lit wherever the current scan position falls on one of a few moving objects: a square ball, two paddles and two seven-segment score digits. The block stores no pixels. Each object is a rectangle, or a set of rectangles, and the scan counters are compared against its live coordinates on every pixel clock.

Game logic feeds the object coordinates and the two scores. The renderer samples them on every clock, so a new position shows on the very next pixel drawn. All timing values, object sizes and fixed screen positions are parameters. The bench uses this to build a scaled-down raster that still has the same structure.

Top module: `mono_scan_renderer`

## Requirements
- R1: While `rst_n` is low, the scan position is held at column 0, line 0, both sync outputs are 1 and `green` is 0.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks. `hsync_n` is 0 exactly when the column is in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC).
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines. `vsync_n` is 0 exactly when the line is in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC).
- R4: `green` is 0 whenever the column is at or above H_VIS or the line is at or above V_VIS, whatever the object inputs.
- R5: Inside the visible area, the ball lights the columns [ball_x, ball_x+BALL_SZ) on the lines [ball_y, ball_y+BALL_SZ).
- R6: Each paddle lights columns [X, X+PAD_W) on lines [Y, Y+PAD_H). X is PADL_X for the left paddle and PADR_X for the right one; Y is that paddle's input.
- R7: A digit with origin (OX, OY), segment length L and thickness T is built from segments at offsets given as (x, y, w, h). The segments are a=(0,0,L,T), b=(L-T,0,T,L), c=(L-T,L,T,L), d=(0,2L-T,L,T), e=(0,L,T,L), f=(0,0,T,L) and g=(0,L,L,T). The values 0 to 9 light the usual segment sets, for example 1 = b,c and 7 = a,b,c. The left score uses origin DIGL_X, the right score uses DIGR_X, and both use DIG_Y.
- R8: Score codes 10 to 15 light no segment.
- R9: Every output is registered. The outputs present the result for the scan position and input values of the previous clock, so an input change shows one clock later, even in the middle of a frame.
- R10: Object extents are compared without wrap-around. A coordinate near the top of its 10-bit range never lights pixels near column 0 or line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ball_x | input | POS_W | Ball left column |
| ball_y | input | POS_W | Ball top line |
| pad_l_y | input | POS_W | Left paddle top line |
| pad_r_y | input | POS_W | Right paddle top line |
| score_l | input | 4 | Left score code |
| score_r | input | 4 | Right score code |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| green | output | 1 | Video bit |

## Verification
The bench builds the block with a reduced raster: 64 visible columns in an 80-clock line, and 48 visible lines in a 55-line frame. The ball is 4 pixels, the paddles are 2x10 and the digits use 6-pixel segments that are 2 pixels thick. A whole frame is only 4400 clocks, so every score pair from 0 to 9 and the blank codes can each get a full frame, every sync edge is crossed many times, and random mid-frame input changes can run for several frames. The small raster also places objects against the right and bottom edges, and coordinates near 1023 probe the wrap-around case.

// File: rtl/scan_render_pkg.sv
package scan_render_pkg;

    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic grn;
    } pix_out_t;

    // bit 0 = a ... bit 6 = g
    function automatic logic [6:0] seg_decode(input logic [3:0] code);
        logic [6:0] m;
        case (code)
            4'd0: m = 7'b0111111;
            4'd1: m = 7'b0000110;
            4'd2: m = 7'b1011011;
            4'd3: m = 7'b1001111;
            4'd4: m = 7'b1100110;
            4'd5: m = 7'b1101101;
            4'd6: m = 7'b1111101;
            4'd7: m = 7'b0000111;
            4'd8: m = 7'b1111111;
            4'd9: m = 7'b1101111;
            default: m = 7'b0000000;
        endcase
        return m;
    endfunction

    function automatic int seg_off_x(input int s, input int l, input int t);
        return (s == 1 || s == 2) ? (l - t) : 0;
    endfunction

    function automatic int seg_off_y(input int s, input int l, input int t);
        case (s)
            2, 4, 6: return l;
            3:       return 2 * l - t;
            default: return 0;
        endcase
    endfunction

    function automatic int seg_w(input int s, input int l, input int t);
        return (s == 0 || s == 3 || s == 6) ? l : t;
    endfunction

    function automatic int seg_h(input int s, input int l, input int t);
        return (s == 0 || s == 3 || s == 6) ? t : l;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525,
    parameter int CW      = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] col,
    output logic [CW-1:0] row
);
    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } cnt_t;

    localparam logic [CW-1:0] H_LAST = CW'(H_TOTAL - 1);
    localparam logic [CW-1:0] V_LAST = CW'(V_TOTAL - 1);

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.h == H_LAST) begin
            cnt_d.h = '0;
            if (cnt_q.v == V_LAST) cnt_d.v = '0;
            else                   cnt_d.v = cnt_q.v + 1'b1;
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign col = cnt_q.h;
    assign row = cnt_q.v;
endmodule

// File: rtl/rect_hit.sv
module rect_hit #(
    parameter int CW = 12,
    parameter int W  = 8,
    parameter int H  = 8
) (
    input  logic [CW-1:0] px,
    input  logic [CW-1:0] py,
    input  logic [CW-1:0] x0,
    input  logic [CW-1:0] y0,
    output logic          hit
);
    localparam logic [CW-1:0] WV = CW'(W);
    localparam logic [CW-1:0] HV = CW'(H);

    logic in_x, in_y;

    always_comb begin
        in_x = (px >= x0) && (px < x0 + WV);
        in_y = (py >= y0) && (py < y0 + HV);
        hit  = in_x && in_y;
    end
endmodule

// File: rtl/digit_hit.sv
module digit_hit #(
    parameter int CW    = 12,
    parameter int ORG_X = 0,
    parameter int ORG_Y = 0,
    parameter int L     = 16,
    parameter int T     = 4
) (
    input  logic [CW-1:0] px,
    input  logic [CW-1:0] py,
    input  logic [3:0]    code,
    output logic          hit
);
    import scan_render_pkg::*;

    localparam int NSEG = 7;

    logic [NSEG-1:0] seg_on;
    logic [NSEG-1:0] seg_mask;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int SX = ORG_X + seg_off_x(s, L, T);
        localparam int SY = ORG_Y + seg_off_y(s, L, T);
        rect_hit #(
            .CW (CW),
            .W  (seg_w(s, L, T)),
            .H  (seg_h(s, L, T))
        ) u_seg (
            .px  (px),
            .py  (py),
            .x0  (CW'(SX)),
            .y0  (CW'(SY)),
            .hit (seg_on[s])
        );
    end

    always_comb begin
        seg_mask = seg_decode(code);
        hit      = |(seg_on & seg_mask);
    end
endmodule

// File: rtl/mono_scan_renderer.sv
module mono_scan_renderer #(
    parameter int POS_W   = 10,
    parameter int H_VIS   = 640,
    parameter int H_FP    = 16,
    parameter int H_SYNC  = 96,
    parameter int H_BP    = 48,
    parameter int V_VIS   = 480,
    parameter int V_FP    = 10,
    parameter int V_SYNC  = 2,
    parameter int V_BP    = 33,
    parameter int BALL_SZ = 8,
    parameter int PAD_W   = 8,
    parameter int PAD_H   = 48,
    parameter int PADL_X  = 16,
    parameter int PADR_X  = 616,
    parameter int DIGL_X  = 256,
    parameter int DIGR_X  = 352,
    parameter int DIG_Y   = 16,
    parameter int SEG_L   = 16,
    parameter int SEG_T   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] ball_x,
    input  logic [POS_W-1:0] ball_y,
    input  logic [POS_W-1:0] pad_l_y,
    input  logic [POS_W-1:0] pad_r_y,
    input  logic [3:0]       score_l,
    input  logic [3:0]       score_r,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             green
);
    import scan_render_pkg::*;

    localparam int H_TOTAL  = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL  = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HC_W     = $clog2(H_TOTAL);
    localparam int VC_W     = $clog2(V_TOTAL);
    localparam int CNT_W    = (HC_W > VC_W) ? HC_W : VC_W;
    localparam int CW       = ((CNT_W > POS_W) ? CNT_W : POS_W) + 1;
    localparam logic [CW-1:0] HS_LO  = CW'(H_VIS + H_FP);
    localparam logic [CW-1:0] HS_HI  = CW'(H_VIS + H_FP + H_SYNC);
    localparam logic [CW-1:0] VS_LO  = CW'(V_VIS + V_FP);
    localparam logic [CW-1:0] VS_HI  = CW'(V_VIS + V_FP + V_SYNC);
    localparam logic [CW-1:0] H_VISV = CW'(H_VIS);
    localparam logic [CW-1:0] V_VISV = CW'(V_VIS);
    localparam int NOBJ = 5;

    logic [CW-1:0] col, row;
    logic [CW-1:0] bx, by, ly, ry;
    logic [NOBJ-1:0] obj_hit;

    scan_timer #(
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL),
        .CW      (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .col   (col),
        .row   (row)
    );

    assign bx = CW'(ball_x);
    assign by = CW'(ball_y);
    assign ly = CW'(pad_l_y);
    assign ry = CW'(pad_r_y);

    rect_hit #(.CW(CW), .W(BALL_SZ), .H(BALL_SZ)) u_ball (
        .px(col), .py(row), .x0(bx), .y0(by), .hit(obj_hit[0])
    );

    rect_hit #(.CW(CW), .W(PAD_W), .H(PAD_H)) u_pad_l (
        .px(col), .py(row), .x0(CW'(PADL_X)), .y0(ly), .hit(obj_hit[1])
    );

    rect_hit #(.CW(CW), .W(PAD_W), .H(PAD_H)) u_pad_r (
        .px(col), .py(row), .x0(CW'(PADR_X)), .y0(ry), .hit(obj_hit[2])
    );

    digit_hit #(
        .CW(CW), .ORG_X(DIGL_X), .ORG_Y(DIG_Y), .L(SEG_L), .T(SEG_T)
    ) u_dig_l (
        .px(col), .py(row), .code(score_l), .hit(obj_hit[3])
    );

    digit_hit #(
        .CW(CW), .ORG_X(DIGR_X), .ORG_Y(DIG_Y), .L(SEG_L), .T(SEG_T)
    ) u_dig_r (
        .px(col), .py(row), .code(score_r), .hit(obj_hit[4])
    );

    pix_out_t out_d, out_q;
    logic     visible;

    always_comb begin
        visible    = (col < H_VISV) && (row < V_VISV);
        out_d.hs_n = !((col >= HS_LO) && (col < HS_HI));
        out_d.vs_n = !((row >= VS_LO) && (row < VS_HI));
        out_d.grn  = visible && (|obj_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{hs_n: 1'b1, vs_n: 1'b1, grn: 1'b0};
        else        out_q <= out_d;
    end

    assign hsync_n = out_q.hs_n;
    assign vsync_n = out_q.vs_n;
    assign green   = out_q.grn;
endmodule

// File: rtl/render_checker.sv
module render_checker #(
    parameter int H_SYNC = 96
) (
    input logic clk,
    input logic rst_n,
    input logic hsync_n,
    input logic vsync_n,
    input logic green
);
    int low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run_q <= 0;
        else if (!hsync_n) low_run_q <= low_run_q + 1;
        else               low_run_q <= 0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (hsync_n && vsync_n && !green));

    assert_hsync_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (low_run_q == H_SYNC));

    assert_vsync_at_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> hsync_n);

    assert_dark_in_hsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !green);

    assert_dark_in_vsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !green);

    assert_known_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({hsync_n, vsync_n, green}));
endmodule

bind mono_scan_renderer render_checker #(.H_SYNC(H_SYNC)) u_render_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .green   (green)
);

// File: tb/tb_mono_scan_renderer.sv
module tb_mono_scan_renderer;
    localparam int CLK_PERIOD = 10;
    localparam int HV = 64, HF = 4, HS = 8, HB = 4;
    localparam int VV = 48, VF = 2, VS = 2, VB = 3;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FRAME = HT * VT;
    localparam int BSZ = 4, PW = 2, PH = 10, PLX = 2, PRX = 60;
    localparam int DLX = 20, DRX = 38, DY = 3, SL = 6, ST = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic [9:0] ball_x = '0, ball_y = '0, pad_l_y = '0, pad_r_y = '0;
    logic [3:0] score_l = '0, score_r = '0;
    logic hsync_n, vsync_n, green;

    mono_scan_renderer #(
        .POS_W(10), .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .BALL_SZ(BSZ), .PAD_W(PW), .PAD_H(PH), .PADL_X(PLX), .PADR_X(PRX),
        .DIGL_X(DLX), .DIGR_X(DRX), .DIG_Y(DY), .SEG_L(SL), .SEG_T(ST)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .ball_x(ball_x), .ball_y(ball_y), .pad_l_y(pad_l_y), .pad_r_y(pad_r_y),
        .score_l(score_l), .score_r(score_r),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .green(green)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    bit active = 0;
    string phase = "R5 R6 R7";

    int mh = 0, mv = 0;
    bit e_hs = 1, e_vs = 1, e_g = 0;
    string e_tag = "R1";

    function automatic bit inside_box(int px, int py, int x0, int y0, int w, int h);
        return (px >= x0) && (px < x0 + w) && (py >= y0) && (py < y0 + h);
    endfunction

    // which segments a score value shows, as a string of letters
    function automatic string lit_set(int code);
        case (code)
            0: return "abcdef";
            1: return "bc";
            2: return "abdeg";
            3: return "abcdg";
            4: return "bcfg";
            5: return "acdfg";
            6: return "acdefg";
            7: return "abc";
            8: return "abcdefg";
            9: return "abcdfg";
            default: return "";
        endcase
    endfunction

    function automatic bit on_digit(int px, int py, int ox, int oy, int code);
        string s;
        bit r;
        s = lit_set(code);
        r = 0;
        for (int i = 0; i < s.len(); i++) begin
            case (s[i])
                "a": r |= inside_box(px, py, ox, oy, SL, ST);
                "b": r |= inside_box(px, py, ox + SL - ST, oy, ST, SL);
                "c": r |= inside_box(px, py, ox + SL - ST, oy + SL, ST, SL);
                "d": r |= inside_box(px, py, ox, oy + 2 * SL - ST, SL, ST);
                "e": r |= inside_box(px, py, ox, oy + SL, ST, SL);
                "f": r |= inside_box(px, py, ox, oy, ST, SL);
                "g": r |= inside_box(px, py, ox, oy + SL, SL, ST);
                default: r |= 0;
            endcase
        end
        return r;
    endfunction

    // reference model, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            mh = 0; mv = 0;
            e_hs = 1; e_vs = 1; e_g = 0; e_tag = "R1";
        end else begin
            bit b, pl, pr, dl, dr, vis;
            e_hs = !(mh >= HV + HF && mh < HV + HF + HS);
            e_vs = !(mv >= VV + VF && mv < VV + VF + VS);
            vis = (mh < HV) && (mv < VV);
            b  = inside_box(mh, mv, int'(ball_x), int'(ball_y), BSZ, BSZ);
            pl = inside_box(mh, mv, PLX, int'(pad_l_y), PW, PH);
            pr = inside_box(mh, mv, PRX, int'(pad_r_y), PW, PH);
            dl = on_digit(mh, mv, DLX, DY, int'(score_l));
            dr = on_digit(mh, mv, DRX, DY, int'(score_r));
            e_g = vis && (b || pl || pr || dl || dr);
            if (!vis)          e_tag = "R4";
            else if (b)        e_tag = "R5";
            else if (pl || pr) e_tag = "R6";
            else if (dl || dr) e_tag = (score_l > 9 || score_r > 9) ? "R8" : "R7";
            else               e_tag = (score_l > 9 || score_r > 9) ? "R8" : "R5 R6 R7";
            mh++;
            if (mh == HT) begin
                mh = 0;
                mv++;
                if (mv == VT) mv = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (active && !done) begin
            n_cmp++;
            if (hsync_n !== e_hs) begin
                n_bad++;
                $display("FAIL R2 [%s] hsync_n=%0b expected %0b at t=%0t", phase, hsync_n, e_hs, $time);
            end else if (vsync_n !== e_vs) begin
                n_bad++;
                $display("FAIL R3 [%s] vsync_n=%0b expected %0b at t=%0t", phase, vsync_n, e_vs, $time);
            end else if (green !== e_g) begin
                n_bad++;
                $display("FAIL %s [%s] green=%0b expected %0b at t=%0t", e_tag, phase, green, e_g, $time);
            end
        end
    end

    task automatic wait_clocks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2 rst_n = 1'b0;
        wait_clocks(3);
        // R1: idle outputs while held in reset
        n_cmp++;
        if (hsync_n !== 1'b1 || vsync_n !== 1'b1 || green !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 outputs=%0b%0b%0b expected 110", hsync_n, vsync_n, green);
        end
        active = 1;
        ball_x = 10'd10; ball_y = 10'd12; pad_l_y = 10'd5; pad_r_y = 10'd30;
        wait_clocks(2);
        rst_n = 1'b1;

        // R5 R6 R7: one frame per score pair
        phase = "R5 R6 R7";
        for (int s = 0; s < 10; s++) begin
            score_l = 4'(s);
            score_r = 4'(9 - s);
            ball_x  = 10'(8 + 5 * s);
            ball_y  = 10'(20 + 2 * s);
            pad_l_y = 10'(3 * s);
            pad_r_y = 10'(37 - 3 * s);
            wait_clocks(FRAME);
        end

        // R8: blank codes
        phase = "R8";
        score_l = 4'd12; score_r = 4'd15;
        wait_clocks(FRAME);
        score_l = 4'd10; score_r = 4'd8;
        wait_clocks(FRAME);

        // R10: objects at edges and near the top of the coordinate range
        phase = "R10";
        score_l = 4'd1; score_r = 4'd1;
        ball_x = 10'd62; ball_y = 10'd46; pad_l_y = 10'd44; pad_r_y = 10'd1020;
        wait_clocks(FRAME);
        ball_x = 10'd1022; ball_y = 10'd1022; pad_l_y = 10'd1019; pad_r_y = 10'd1023;
        wait_clocks(FRAME);

        // R9: inputs move every few clocks in the middle of frames
        phase = "R9";
        for (int k = 0; k < 3 * FRAME / 37; k++) begin
            ball_x  = 10'($urandom_range(0, 70));
            ball_y  = 10'($urandom_range(0, 52));
            pad_l_y = 10'($urandom_range(0, 50));
            pad_r_y = 10'($urandom_range(0, 50));
            score_l = 4'($urandom_range(0, 15));
            score_r = 4'($urandom_range(0, 15));
            wait_clocks(37);
        end

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule